// File: doc/BRIEF.md
# Jump-Sequence Counter

This block is a synchronous counter whose 4-bit output repeats a fixed cycle with gaps: 15, 0, 1, 2, 8, 9, 10, 6, 7, and then 15 again. It is built from a plain modulo-16 binary counter that has a parallel-load input. A small combinational decoder watches the present count. At the three points where the next value is not count+1, the decoder asserts load and supplies the target value. Every other step, including the wrap from 15 to 0, is the counter's own increment.

A synchronous reset places the count at the first value of the cycle. A low enable freezes the count and suppresses any load. The seven codes that are not in the cycle reach it by plain increments within a small fixed number of clocks. Codes 3 to 5 climb to 6, and codes 11 to 14 climb to 15. The reset value is a parameter so that these entry paths can be exercised directly.

Top module: `seqjump_counter`

## Requirements
- R1: While rst is high at a rising clock edge, count takes the value INIT_CODE (default 15) at that edge.
- R2: With en high, count 15 steps to 0 through the counter's natural wrap.
- R3: With en high, counts 0, 1, 8, 9 and 6 step to 1, 2, 9, 10 and 7 respectively.
- R4: With en high, count 2 steps to 8.
- R5: With en high, count 10 steps to 6.
- R6: With en high, count 7 steps to 15.
- R7: With en low, count keeps its value at every edge, including at the jump points 2, 10 and 7.
- R8: Starting from an unused code c (3, 4, 5, 11, 12, 13, 14) with en high, count rises by one per clock. It reaches 6 after 6-c clocks when c is below 6, and it reaches 15 after 15-c clocks when c is above 10.
- R9: With en high, the cycle of nine values repeats with no other value appearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low holds the value |
| count | output | 4 | Present sequence value |

## Verification
The bench builds one instance with the default reset value of 15 and seven more instances with INIT_CODE set to each unused code. Those parameter values put every off-cycle code at the output straight after reset. This lets the climb back into the cycle be followed clock by clock without touching internal state. The default instance is run through two full cycles, and its enable is dropped exactly at the three jump points.

// File: rtl/seqjump_pkg.sv
package seqjump_pkg;
    localparam int CNT_W   = 4;
    localparam int N_JUMPS = 3;
    localparam int SEQ_LEN = 9;

    typedef logic [CNT_W-1:0] code_t;

    // Codes where the increment is replaced by a load, and the loaded value.
    localparam code_t JMP_SRC [N_JUMPS] = '{4'd2, 4'd10, 4'd7};
    localparam code_t JMP_DST [N_JUMPS] = '{4'd8, 4'd6,  4'd15};

    function automatic logic in_cycle(code_t c);
        return (c == 4'd15) || (c <= 4'd2) || (c >= 4'd6 && c <= 4'd10);
    endfunction
endpackage

// File: rtl/bincnt_core.sv
module bincnt_core #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (ld) st_d.cnt = ld_val;
            else    st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cnt <= RST_VAL;
        else     st_q     <= st_d;
    end

    assign q = st_q.cnt;

    // Load takes priority over increment; a wrap needs no load (R2, R4)
    assert_load_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (en && ld) |=> (q == $past(ld_val)));
    assert_incr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !ld) |=> (q == W'($past(q) + 1'b1)));
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(q));
endmodule

// File: rtl/jump_decode.sv
module jump_decode
    import seqjump_pkg::*;
(
    input  code_t cur,
    output logic  ld,
    output code_t tgt
);
    logic [N_JUMPS-1:0] hit;

    for (genvar i = 0; i < N_JUMPS; i++) begin : g_src
        assign hit[i] = (cur == JMP_SRC[i]);
    end

    always_comb begin
        ld  = |hit;
        tgt = '0;
        for (int i = 0; i < N_JUMPS; i++) begin
            if (hit[i]) tgt = tgt | JMP_DST[i];
        end
    end

    // At most one jump source can match a given count (R9)
    always_comb begin
        assert_one_jump_R9: assert ($onehot0(hit));
    end
endmodule

// File: rtl/seqjump_counter.sv
module seqjump_counter
    import seqjump_pkg::*;
#(
    parameter logic [3:0] INIT_CODE = 4'd15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [3:0] count
);
    logic  jmp_ld;
    code_t jmp_val;
    code_t cnt_q;

    jump_decode u_dec (
        .cur (cnt_q),
        .ld  (jmp_ld),
        .tgt (jmp_val)
    );

    bincnt_core #(
        .W       (CNT_W),
        .RST_VAL (INIT_CODE)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .ld     (jmp_ld),
        .ld_val (jmp_val),
        .q      (cnt_q)
    );

    assign count = cnt_q;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (count == INIT_CODE));
    assert_jump_2_R4: assert property (@(posedge clk) disable iff (rst)
        (en && count == 4'd2) |=> (count == 4'd8));
    assert_jump_10_R5: assert property (@(posedge clk) disable iff (rst)
        (en && count == 4'd10) |=> (count == 4'd6));
    assert_jump_7_R6: assert property (@(posedge clk) disable iff (rst)
        (en && count == 4'd7) |=> (count == 4'd15));
    assert_stay_in_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (in_cycle(count)) |=> in_cycle(count));
    assert_climb_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !in_cycle(count)) |=> (count == 4'($past(count) + 1'b1)));
endmodule

// File: tb/tb_seqjump_counter.sv
`timescale 1ns/1ps
module tb_seqjump_counter;
    localparam int N_UN = 7;
    localparam logic [3:0] UNUSED [N_UN] = '{4'd3, 4'd4, 4'd5, 4'd11, 4'd12, 4'd13, 4'd14};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] count;
    logic [3:0] rec_cnt [N_UN];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    seqjump_counter dut (.clk(clk), .rst(rst), .en(en), .count(count));

    for (genvar i = 0; i < N_UN; i++) begin : g_rec
        seqjump_counter #(.INIT_CODE(UNUSED[i])) u_rec (
            .clk(clk), .rst(rst), .en(en), .count(rec_cnt[i]));
    end

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string req_for(logic [3:0] prev);
        case (prev)
            4'd15:   return "R2";
            4'd2:    return "R4";
            4'd10:   return "R5";
            4'd7:    return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", count, 4'd15);
        for (int i = 0; i < N_UN; i++) check("R1", rec_cnt[i], UNUSED[i]);
    endtask

    task automatic t_full_cycle();
        logic [3:0] seq [9] = '{4'd15, 4'd0, 4'd1, 4'd2, 4'd8, 4'd9, 4'd10, 4'd6, 4'd7};
        do_reset();
        en = 1'b1;
        for (int k = 1; k <= 18; k++) begin
            step();
            check(k > 9 ? "R9" : req_for(seq[(k-1) % 9]), count, seq[k % 9]);
        end
        en = 1'b0;
    endtask

    task automatic t_hold();
        logic [3:0] stops [3] = '{4'd2, 4'd10, 4'd7};
        do_reset();
        foreach (stops[s]) begin
            en = 1'b1;
            while (count != stops[s]) step();
            en = 1'b0;
            for (int k = 0; k < 3; k++) begin
                step();
                check("R7", count, stops[s]);
            end
        end
        en = 1'b1;
        step();
        check("R6", count, 4'd15);
        en = 1'b0;
    endtask

    task automatic t_recovery();
        do_reset();
        en = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            step();
            for (int i = 0; i < N_UN; i++) begin
                int tgt = (UNUSED[i] < 4'd6) ? 6 : 15;
                int exp = int'(UNUSED[i]) + k;
                if (exp <= tgt) check("R8", rec_cnt[i], 4'(exp));
            end
        end
        en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_full_cycle();
        t_hold();
        t_recovery();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: count=%0d expected=done", count);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule